// File: doc/BRIEF.md
# Indexed Byte Port Bridge with Lockable Windows

This block puts a byte-wide memory of up to 8 KB behind a window of four I/O port offsets. A host never presents a full address. It writes the low address byte to one offset and the high address byte to another. It then reads or writes the data offset, and that access goes to the byte held in a 16-bit address latch. After a data write the latch returns to zero, so the next data access needs a fresh address unless the host means address zero.

Two 16-byte address windows, 0x20..0x2F and 0x30..0x3F, each have a lock bit. A one-cycle pulse on a toggle input flips the matching lock bit. While a window is locked, data reads in it return 0xFF and data writes to it are dropped. Addresses at or beyond the memory size behave the same way. Read data comes back registered on `rdata` and holds until the next read.

Top module: `idx_port_bridge`

## Requirements
- R1: A write (`wr_en`=1) at port offset 0 loads `wdata` into bits 7:0 of the address latch and leaves bits 15:8 unchanged.
- R2: A write at port offset 1 loads `wdata` into bits 15:8 of the address latch and leaves bits 7:0 unchanged.
- R3: A write at port offset 3 stores `wdata` at the latched address and sets the latch to 0x0000 on the same edge.
- R4: A read (`rd_en`=1, `wr_en`=0) at port offset 3 puts the byte at the latched address on `rdata` after the next rising edge and leaves the latch unchanged.
- R5: While lock bit 0 is set, data reads at addresses 0x20..0x2F return 0xFF and data writes there have no effect. Neighbouring addresses are unaffected.
- R6: While lock bit 1 is set, data reads at addresses 0x30..0x3F return 0xFF and data writes there have no effect.
- R7: A pulse on `lock_toggle[n]` inverts lock bit n on that edge. An access in the same cycle still sees the old lock value.
- R8: A data read at an address of MEM_BYTES (1024 by default) or above returns 0xFF. A data write there changes no stored byte.
- R9: Reads at offsets 0, 1 and 2 return 0xFF. A write at offset 2 changes neither the latch nor memory.
- R10: Reset clears the address latch and both lock bits and sets `rdata` to 0xFF. Memory contents are unspecified after reset.
- R11: When `wr_en` and `rd_en` are both high, only the write is carried out and `rdata` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_sel | input | 2 | Port offset: 0 low address, 1 high address, 2 unused, 3 data |
| wr_en | input | 1 | Write strobe for one cycle |
| rd_en | input | 1 | Read strobe for one cycle |
| wdata | input | 8 | Write byte |
| lock_toggle | input | 2 | Per-window lock invert pulse |
| rdata | output | 8 | Registered read byte |

## Verification
Every effect of a request lands on the rising edge that samples it. The address latch and the lock bits change on that edge. Read data appears on `rdata` one edge after `rd_en` and holds until the next read. The bench drives each request just after a falling edge and lets one rising edge pass. It then compares `rdata` with its reference model at the following falling edge. Latch, lock and ignored-write effects are observed through later data reads at chosen addresses.

// File: rtl/bridge_pkg.sv
package bridge_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 2 * BYTE_W;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [1:0] {
        OFS_ADDR_LO = 2'd0,
        OFS_ADDR_HI = 2'd1,
        OFS_SPARE   = 2'd2,
        OFS_DATA    = 2'd3
    } port_ofs_e;

    typedef struct packed {
        addr_t addr;
        byte_t rdata;
    } bridge_state_t;

    localparam byte_t EMPTY_BYTE = '1;
endpackage

// File: rtl/bridge_lock.sv
module bridge_lock
    import bridge_pkg::*;
#(
    parameter int NUM_LOCKS = 2,
    parameter int LOCK_BASE = 32,
    parameter int LOCK_SPAN = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LOCKS-1:0] toggle,
    input  addr_t                addr,
    output logic                 blocked
);
    logic [NUM_LOCKS-1:0] lock_d, lock_q, hit;

    always_comb begin
        lock_d = lock_q ^ toggle;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lock_q <= '0;
        else        lock_q <= lock_d;
    end

    for (genvar i = 0; i < NUM_LOCKS; i++) begin : g_win
        localparam int WIN_LO = LOCK_BASE + i * LOCK_SPAN;
        localparam int WIN_HI = WIN_LO + LOCK_SPAN;
        assign hit[i] = ({16'd0, addr} >= 32'(WIN_LO)) && ({16'd0, addr} < 32'(WIN_HI));

        // R7
        lock_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
            toggle[i] |=> lock_q[i] != $past(lock_q[i]));
        // R7
        lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !toggle[i] |=> $stable(lock_q[i]));
    end

    assign blocked = |(hit & lock_q);
endmodule

// File: rtl/bridge_store.sv
module bridge_store
    import bridge_pkg::*;
#(
    parameter int MEM_BYTES = 1024
) (
    input  logic  clk,
    input  logic  we,
    input  addr_t addr,
    input  byte_t wdata,
    output byte_t rdata,
    output logic  in_range
);
    localparam int IDX_W = (MEM_BYTES > 1) ? $clog2(MEM_BYTES) : 1;

    byte_t             mem [MEM_BYTES];
    logic [IDX_W-1:0]  idx;

    assign idx      = addr[IDX_W-1:0];
    assign in_range = ({16'd0, addr} < 32'(MEM_BYTES));
    assign rdata    = in_range ? mem[idx] : EMPTY_BYTE;

    always_ff @(posedge clk) begin
        if (we && in_range) mem[idx] <= wdata;
    end
endmodule

// File: rtl/idx_port_bridge.sv
module idx_port_bridge
    import bridge_pkg::*;
#(
    parameter int MEM_BYTES = 1024,
    parameter int NUM_LOCKS = 2,
    parameter int LOCK_BASE = 32,
    parameter int LOCK_SPAN = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           port_sel,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic [7:0]           wdata,
    input  logic [NUM_LOCKS-1:0] lock_toggle,
    output logic [7:0]           rdata
);
    localparam int HALF = ADDR_W / 2;

    bridge_state_t state_d, state_q;
    port_ofs_e     ofs;
    logic          blocked, in_range, mem_we, do_rd;
    byte_t         mem_rdata;

    assign ofs   = port_ofs_e'(port_sel);
    assign do_rd = rd_en && !wr_en;

    bridge_lock #(
        .NUM_LOCKS(NUM_LOCKS),
        .LOCK_BASE(LOCK_BASE),
        .LOCK_SPAN(LOCK_SPAN)
    ) u_lock (
        .clk    (clk),
        .rst_n  (rst_n),
        .toggle (lock_toggle),
        .addr   (state_q.addr),
        .blocked(blocked)
    );

    bridge_store #(
        .MEM_BYTES(MEM_BYTES)
    ) u_store (
        .clk     (clk),
        .we      (mem_we),
        .addr    (state_q.addr),
        .wdata   (wdata),
        .rdata   (mem_rdata),
        .in_range(in_range)
    );

    always_comb begin
        state_d = state_q;
        mem_we  = 1'b0;
        if (wr_en) begin
            unique case (ofs)
                OFS_ADDR_LO: state_d.addr[HALF-1:0]      = wdata;
                OFS_ADDR_HI: state_d.addr[ADDR_W-1:HALF] = wdata;
                OFS_DATA: begin
                    mem_we        = !blocked;
                    state_d.addr  = '0;
                end
                default: ;
            endcase
        end else if (do_rd) begin
            if (ofs == OFS_DATA && in_range && !blocked) state_d.rdata = mem_rdata;
            else                                         state_d.rdata = EMPTY_BYTE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.addr  <= '0;
            state_q.rdata <= EMPTY_BYTE;
        end else begin
            state_q <= state_d;
        end
    end

    assign rdata = state_q.rdata;

    // R1
    lo_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && port_sel == 2'd0 |=> state_q.addr[7:0] == $past(wdata)
                                   && state_q.addr[15:8] == $past(state_q.addr[15:8]));
    // R2
    hi_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && port_sel == 2'd1 |=> state_q.addr[15:8] == $past(wdata)
                                   && state_q.addr[7:0] == $past(state_q.addr[7:0]));
    // R3
    latch_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && port_sel == 2'd3 |=> state_q.addr == '0);
    // R4
    read_keeps_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && !wr_en |=> $stable(state_q.addr));
    // R9
    ctrl_read_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && !wr_en && port_sel != 2'd3 |=> rdata == 8'hFF);
    // R5
    blocked_read_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && !wr_en && port_sel == 2'd3 && blocked |=> rdata == 8'hFF);
    // R11
    write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> $stable(rdata));
endmodule

// File: tb/idx_port_bridge_bench.sv
module idx_port_bridge_bench;
    localparam int CLK_PERIOD = 10;
    localparam int MEM = 1024;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] port_sel = '0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [1:0] lock_toggle = '0;
    logic [7:0] rdata;

    int checks = 0, errors = 0;

    int mem_m [MEM];
    int addr_m = 0;
    int lock_m = 0;
    int exp_rd = 255;

    always #(CLK_PERIOD/2) clk = ~clk;

    idx_port_bridge u_idx_port_bridge (
        .clk(clk), .rst_n(rst_n), .port_sel(port_sel), .wr_en(wr_en),
        .rd_en(rd_en), .wdata(wdata), .lock_toggle(lock_toggle), .rdata(rdata)
    );

    function automatic bit is_blocked(int a);
        return ((lock_m & 1) != 0 && a >= 32 && a < 48) ||
               ((lock_m & 2) != 0 && a >= 48 && a < 64);
    endfunction

    task automatic check_rd(string tag);
        if (exp_rd < 0) return;
        checks++;
        if (rdata !== 8'(exp_rd)) begin
            errors++;
            $display("FAIL %s: rdata=%02h expected=%02h", tag, rdata, exp_rd);
        end
    endtask

    // one request per cycle; model updated at the edge, output compared at the next falling edge
    task automatic cyc(int p, bit w, bit r, int d, int tog, string tag);
        port_sel = 2'(p); wr_en = w; rd_en = r; wdata = 8'(d); lock_toggle = 2'(tog);
        @(posedge clk);
        if (w) begin
            case (p)
                0: addr_m = (addr_m & 16'hFF00) | d;
                1: addr_m = (addr_m & 16'h00FF) | (d << 8);
                3: begin
                    if (addr_m < MEM && !is_blocked(addr_m)) mem_m[addr_m] = d;
                    addr_m = 0;
                end
                default: ;
            endcase
        end else if (r) begin
            if (p == 3 && addr_m < MEM && !is_blocked(addr_m)) exp_rd = mem_m[addr_m];
            else exp_rd = 255;
        end
        lock_m = lock_m ^ tog;
        @(negedge clk);
        port_sel = '0; wr_en = 0; rd_en = 0; lock_toggle = '0;
        check_rd(tag);
    endtask

    task automatic set_addr(int a, string tag);
        cyc(0, 1, 0, a & 255, 0, tag);
        cyc(1, 1, 0, (a >> 8) & 255, 0, tag);
    endtask

    task automatic poke(int a, int v, string tag);
        set_addr(a, tag);
        cyc(3, 1, 0, v, 0, tag);
    endtask

    task automatic peek(int a, string tag);
        set_addr(a, tag);
        cyc(3, 0, 1, 0, 0, tag);
    endtask

    task automatic do_reset();
        rst_n = 0; wr_en = 0; rd_en = 0; lock_toggle = '0;
        repeat (2) @(posedge clk);
        addr_m = 0; lock_m = 0; exp_rd = 255;
        for (int i = 0; i < MEM; i++) mem_m[i] = -1;
        @(negedge clk);
        rst_n = 1;
        check_rd("R10 reset rdata");
    endtask

    initial begin
        do_reset();
        // R1 R2 R3 R4: byte-wise address loading and data access
        poke(16'h0134, 8'h9C, "R3 write");
        peek(16'h0134, "R4 read");
        cyc(3, 0, 1, 0, 0, "R4 repeat read keeps latch");
        poke(16'h0210, 8'h41, "R3 write");
        poke(16'h0010, 8'h66, "R3 write");
        cyc(1, 1, 0, 8'h02, 0, "R2 hi");
        cyc(0, 1, 0, 8'h11, 0, "R1 lo");
        cyc(0, 1, 0, 8'h10, 0, "R1 lo keeps hi");
        cyc(3, 0, 1, 0, 0, "R1 read 0x0210");
        cyc(1, 1, 0, 8'h00, 0, "R2 hi keeps lo");
        cyc(3, 0, 1, 0, 0, "R2 read 0x0010");
        poke(0, 8'h77, "R3 write 0");
        cyc(3, 1, 0, 8'h12, 0, "R3 write after clear");
        cyc(3, 0, 1, 0, 0, "R3 latch cleared read 0");
        // R5 R6 R7: lock windows
        poke(16'h1F, 8'h01, "R5 setup");
        poke(16'h25, 8'hAB, "R5 setup");
        poke(16'h2F, 8'hBC, "R5 setup");
        poke(16'h35, 8'hCD, "R6 setup");
        poke(16'h40, 8'hDE, "R6 setup");
        set_addr(16'h25, "R7 addr");
        cyc(3, 0, 1, 0, 1, "R7 same-cycle read sees old lock");
        peek(16'h25, "R5 locked read");
        peek(16'h2F, "R5 locked top");
        peek(16'h1F, "R5 below window");
        peek(16'h35, "R5 other window open");
        poke(16'h2F, 8'h00, "R5 locked write");
        cyc(0, 0, 0, 0, 3, "R7 toggle both");
        peek(16'h2F, "R5 write was dropped");
        peek(16'h35, "R6 locked read");
        poke(16'h30, 8'h55, "R6 locked write");
        peek(16'h40, "R6 above window");
        cyc(0, 0, 0, 0, 2, "R7 unlock 1");
        peek(16'h30, "R6 write was dropped");
        peek(16'h35, "R6 unlocked read");
        // R8: out of range
        poke(16'h0400, 8'hEE, "R8 write beyond");
        peek(0, "R8 no alias at 0");
        peek(16'h0400, "R8 read beyond");
        poke(16'hFFFF, 8'h33, "R8 write top");
        peek(16'h03FF, "R8 no alias at 3FF");
        peek(16'hFFFF, "R8 read top");
        // R9: control offsets
        set_addr(16'h0134, "R9 addr");
        cyc(0, 0, 1, 0, 0, "R9 read ofs0");
        cyc(3, 0, 1, 0, 0, "R9 restore rdata");
        cyc(1, 0, 1, 0, 0, "R9 read ofs1");
        cyc(2, 0, 1, 0, 0, "R9 read ofs2");
        cyc(2, 1, 0, 8'h5A, 0, "R9 write ofs2");
        cyc(3, 0, 1, 0, 0, "R9 latch and memory intact");
        // R11: write and read together
        cyc(0, 1, 1, 8'h25, 0, "R11 write wins");
        cyc(3, 0, 1, 0, 0, "R11 latch took write");
        // R10: reset clears latch and locks
        cyc(0, 0, 0, 0, 1, "R10 lock before reset");
        set_addr(16'h0005, "R10 latch before reset");
        do_reset();
        cyc(3, 1, 0, 8'hA5, 0, "R10 write at cleared latch");
        poke(16'h0005, 8'h3C, "R10 setup");
        cyc(3, 0, 1, 0, 0, "R10 latch was zero");
        poke(16'h25, 8'h99, "R10 lock cleared write");
        peek(16'h25, "R10 lock cleared read");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        errors++; checks++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule